// File: doc/BRIEF.md
# Banked Word RAM with Chip Select

This block is a synchronous random-access memory put together from identical byte-wide storage banks. Each bank and the top level have the same interface: a chip select, a write/read select, an address, a write-data bus and a read-data bus. A whole memory therefore looks like any one of its parts.

Depth comes from four bank rows. The two top address bits drive a 2-to-4 decoder whose outputs act as the chip selects of the rows. The lower address bits go to every bank unchanged. Width comes from placing two byte-wide banks side by side in each row. Both banks see the same address and control, and each stores one byte of the 16-bit word.

The read data of the rows is combined through an AND-OR select keyed by a registered one-hot read select, in place of shared tri-state lines. With the default parameters the top level holds 256 words of 16 bits behind an 8-bit address.

Top module: `bram_banked`

## Requirements
- R1: While `cs` is 0, no location changes, whatever `we` and `wdata` are, and `rdata` is all zeros in the following cycle.
- R2: With `cs`=1 and `we`=0 at a rising edge, `rdata` shows the word stored at `addr` after that edge.
- R3: With `cs`=1 and `we`=1 at a rising edge, `wdata` is stored at `addr`, and `rdata` is all zeros after that edge.
- R4: Address bits [7:6] pick the bank row in ascending order: 00 maps to 0x00-0x3F, 01 to 0x40-0x7F, 10 to 0x80-0xBF and 11 to 0xC0-0xFF. Every one of the 256 addresses holds its own word.
- R5: A write changes only the row whose chip select is raised. A word written at one low address in one row leaves the same low address in the other three rows unchanged.
- R6: Read data has exactly one cycle of latency. It is registered at the edge that samples the read and stays there until the next edge.
- R7: At most one row drives the merged output. When no read was sampled at the previous edge, the merged output is all zeros.
- R8: Bits [15:8] and bits [7:0] of a word are kept in separate byte banks. Both are written together and read back together, including words whose two bytes differ.
- R9: While `rst_n` is 0 and after it is released, `rdata` is all zeros until the first read.
- R10: `wdata` is ignored during a read. It neither changes the stored word nor appears on `rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; 0 means no operation |
| we | input | 1 | 1 = write, 0 = read, when `cs` is 1 |
| addr | input | 8 | Word address; bits [7:6] select the bank row |
| wdata | input | 16 | Word to store |
| rdata | output | 16 | Registered read word, or zeros |

## Verification
The bench builds the block with its default parameters: 6-bit bank address, 8-bit bank width, 2 select bits and 2 lanes. This keeps the array at 256 words, so every address can be written with its own pattern and read back in a few hundred cycles. That covers all four decoder outputs and both byte lanes, and makes aliasing between rows visible. The table vectors reuse one low address across the four rows and sit on the 0x3F/0x40 row boundary, where a decoding fault would show.

// File: rtl/bram_pkg.sv
package bram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bram_op_e;

  function automatic bram_op_e decode_op(input logic cs, input logic we);
    if (!cs)     return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction

endpackage

// File: rtl/bram_decoder.sv
module bram_decoder #(
  parameter int SEL_W = 2,
  localparam int N    = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] code,
  output logic [N-1:0]     onehot
);

  for (genvar i = 0; i < N; i++) begin : g_out
    assign onehot[i] = en && (code == SEL_W'(i));
  end

endmodule

// File: rtl/bram_bank.sv
module bram_bank #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic          wr_en;
  logic          rd_en;
  logic [DW-1:0] rd_d;
  logic [DW-1:0] rd_q;

  assign wr_en = sel && wr;
  assign rd_en = sel && !wr;

  // storage array: no reset, written only under its own enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = mem[addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/bram_merge.sv
module bram_merge #(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic [N-1:0]    sel,
  input  logic [N*DW-1:0] data,
  output logic [DW-1:0]   out
);

  always_comb begin
    out = '0;
    for (int i = 0; i < N; i++) begin
      out = out | (data[i*DW +: DW] & {DW{sel[i]}});
    end
  end

endmodule

// File: rtl/bram_banked.sv
module bram_banked
  import bram_pkg::*;
#(
  parameter int BANK_AW = 6,
  parameter int BANK_DW = 8,
  parameter int SEL_W   = 2,
  parameter int LANES   = 2,
  localparam int AW     = BANK_AW + SEL_W,
  localparam int DW     = BANK_DW * LANES,
  localparam int NB     = 1 << SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  bram_op_e         op;
  logic [SEL_W-1:0] row_code;
  logic [BANK_AW-1:0] low_addr;
  logic [NB-1:0]    bank_cs;
  logic [NB-1:0]    rd_sel_d;
  logic [NB-1:0]    rd_sel_q;
  logic [NB*DW-1:0] row_flat;

  assign op       = decode_op(cs, we);
  assign row_code = addr[AW-1 -: SEL_W];
  assign low_addr = addr[BANK_AW-1:0];

  bram_decoder #(.SEL_W(SEL_W)) u_dec (
    .en     (cs),
    .code   (row_code),
    .onehot (bank_cs)
  );

  for (genvar b = 0; b < NB; b++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      bram_bank #(.AW(BANK_AW), .DW(BANK_DW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bank_cs[b]),
        .wr    (we),
        .addr  (low_addr),
        .wdata (wdata[l*BANK_DW +: BANK_DW]),
        .rdata (row_flat[b*DW + l*BANK_DW +: BANK_DW])
      );
    end
  end

  // which row owns the registered read data
  always_comb begin
    rd_sel_d = '0;
    if (op == OP_READ) begin
      rd_sel_d = bank_cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel_q <= '0;
    end else begin
      rd_sel_q <= rd_sel_d;
    end
  end

  bram_merge #(.N(NB), .DW(DW)) u_merge (
    .sel  (rd_sel_q),
    .data (row_flat),
    .out  (rdata)
  );

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cs)); // R7
  AST_CS_LOW_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (bank_cs == '0)); // R1
  AST_ROW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> bank_cs[row_code]); // R4
  AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !we) |=> (rdata == '0)); // R7
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we) ##1 (cs && !we && $stable(addr)) |=> $stable(rdata)); // R6

endmodule

// File: tb/bram_banked_bench.sv
`timescale 1ns/1ps
module bram_banked_bench;

  logic        clk;
  logic        rst_n;
  logic        cs;
  logic        we;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;

  int applied;
  int fails;
  bit done;

  bram_banked u_bram_banked (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        cs;
    logic        we;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'h05, 16'hA1B2, 16'h0000, 8'd3},  // R3 write row 0
    '{1'b1, 1'b1, 8'h45, 16'hC3D4, 16'h0000, 8'd5},  // R5 same low addr row 1
    '{1'b1, 1'b1, 8'h85, 16'hE5F6, 16'h0000, 8'd5},  // R5 row 2
    '{1'b1, 1'b1, 8'hC5, 16'h1728, 16'h0000, 8'd5},  // R5 row 3
    '{1'b1, 1'b0, 8'h05, 16'h0000, 16'hA1B2, 8'd2},  // R2 read row 0
    '{1'b1, 1'b0, 8'h45, 16'h0000, 16'hC3D4, 8'd5},  // R5
    '{1'b1, 1'b0, 8'h85, 16'h0000, 16'hE5F6, 8'd5},  // R5
    '{1'b1, 1'b0, 8'hC5, 16'h0000, 16'h1728, 8'd4},  // R4
    '{1'b0, 1'b1, 8'h05, 16'hFFFF, 16'h0000, 8'd1},  // R1 write with cs low
    '{1'b1, 1'b0, 8'h05, 16'h9999, 16'hA1B2, 8'd10}, // R10 wdata ignored, R1 unchanged
    '{1'b0, 1'b0, 8'h05, 16'h0000, 16'h0000, 8'd7},  // R7 no row selected
    '{1'b1, 1'b1, 8'h3F, 16'h00FF, 16'h0000, 8'd4},  // R4 top of row 0
    '{1'b1, 1'b1, 8'h40, 16'hFF00, 16'h0000, 8'd4},  // R4 bottom of row 1
    '{1'b1, 1'b0, 8'h3F, 16'h1234, 16'h00FF, 8'd8},  // R8 byte lanes
    '{1'b1, 1'b0, 8'h40, 16'h0000, 16'hFF00, 8'd8}   // R8
  };

  function automatic logic [15:0] pat(input int a);
    return {8'(a) ^ 8'h5A, 8'(a)};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    applied++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%0h got=%h expected=%h", req, addr, rdata, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(input logic c, input logic w, input logic [7:0] a,
                      input logic [15:0] d);
    cs = c; we = w; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    applied = 0; fails = 0; done = 0;
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R9", 16'h0000);           // R9 in reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", 16'h0000);           // R9 after release

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].cs, VECS[i].we, VECS[i].addr, VECS[i].wd);
      check($sformatf("R%0d", VECS[i].req), VECS[i].exp);
    end

    // R4 R8: unique pattern at every address
    for (int a = 0; a < 256; a++) begin
      step(1'b1, 1'b1, 8'(a), pat(a));
      if (a % 32 == 0) check("R3", 16'h0000);
    end
    for (int a = 0; a < 256; a++) begin
      step(1'b1, 1'b0, 8'(a), 16'h0000);
      check("R4", pat(a));
    end

    // R1: writes with cs low across all rows leave contents intact
    for (int a = 0; a < 256; a += 37) begin
      step(1'b0, 1'b1, 8'(a), ~pat(a));
      check("R1", 16'h0000);
    end
    for (int a = 0; a < 256; a += 37) begin
      step(1'b1, 1'b0, 8'(a), ~pat(a));
      check("R1", pat(a));
    end

    // R5: rewrite one row, neighbours at same low address unchanged
    step(1'b1, 1'b1, 8'h92, 16'hBEEF);
    step(1'b1, 1'b0, 8'h12, 16'h0000); check("R5", pat(8'h12));
    step(1'b1, 1'b0, 8'h52, 16'h0000); check("R5", pat(8'h52));
    step(1'b1, 1'b0, 8'h92, 16'h0000); check("R5", 16'hBEEF);
    step(1'b1, 1'b0, 8'hD2, 16'h0000); check("R5", pat(8'hD2));

    // R6: one cycle latency, data stays until next edge
    step(1'b1, 1'b0, 8'hD2, 16'h0000);
    check("R6", pat(8'hD2));
    step(1'b0, 1'b0, 8'hD2, 16'h0000);
    check("R7", 16'h0000);

    done = 1;
    finish_run();
  end

endmodule